// File: doc/BRIEF.md
# Serial peripheral interface controller with sequenced status flags

This block moves one byte at a time over a four-wire synchronous serial link. It acts either as the clock-driving side (master) or as the clock-following side (slave). Software reaches it through a small register port that has four addresses: control, status, data and clock divisor. In master mode, a write to the data address loads the outgoing byte and starts the transfer. The serial clock period is a programmed number of system clock cycles. In slave mode, a data write only loads the byte that goes out on the next transfer the remote master clocks in.

The status register holds five sticky flags: transfer done, write clash, receive overrun, select fault and slave abort. Each flag is cleared by its own sequence of register accesses, so the block keeps track of which flags a status read has already shown. A data write that arrives while a byte is in flight, or while a completed byte has not yet been acknowledged by a status read, is dropped and raises the write-clash flag.

Top module: `spi_unit`

## Requirements
- R1: The register addresses are 0 control, 1 status, 2 data and 3 divisor. Every register reads 0 after reset. Control keeps only its bits 3:0 (bit 0 phase, bit 1 idle clock level, bit 2 master, bit 3 least-significant-bit first), and its bits 7:4 read 0. The divisor reads back the value written to it. Read data appears on `bus_rdata` one cycle after the read strobe.
- R2: In master mode, an accepted data write sends the byte on `sdo_o` and captures `sdi_i` over eight serial clock periods. `sck_o` rests at the programmed idle level between transfers. The byte captured last is returned by a data read.
- R3: A data write is ignored while a transfer is in progress, and also while the done flag is set but has not been shown by a status read since it was set. Such a write sets the write-clash flag (status bit 6), and the received byte stays unchanged.
- R4: In master mode, the done flag (status bit 7) is set exactly 8·P cycles after the clock edge that accepts the data write, where P is the effective divisor.
- R5: The done flag and the write-clash flag clear only when a status read that showed them is followed by a data read or a data write. A data access without such a status read leaves them set.
- R6: The effective divisor P is the programmed value if that value is even and at least 8; otherwise P is 8. The serial clock changes level every P/2 cycles.
- R7: In slave mode, releasing `ss_n_i` after at least one bit has been sampled, and before the eighth, sets the abort flag (status bit 3). Any status read clears it.
- R8: Driving `ss_n_i` low while in master mode sets the select-fault flag (status bit 4) and clears the master bit. The flag clears only when a status read that showed it is followed by a control write.
- R9: In slave mode, with phase 0 and idle level 0, the block samples `sdi_i` on rising `sck_i` and shifts `sdo_o` on falling `sck_i`, in the selected bit order. The done flag is set on the eighth sampling edge.
- R10: If a slave byte completes while the done flag is still set, the overrun flag (status bit 5) is set and the earlier received byte is kept. Any status read clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DW | Register write data |
| bus_rdata | output | DW | Registered read data |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select input |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data out of the block |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, an 8-bit divisor and a minimum divisor of 8. With these values the master table can program divisors of 0, 5 and 9, which all fall back to 8, and valid divisors of 12 and 20. The exact cycle in which the done flag rises then shows both the fallback rule and the half-period clock. An 8-bit path keeps each slave byte short enough for the bench to clock it by hand. That brings the bit-order, overrun, abort and select-fault sequences within reach of directed tests.

// File: rtl/spi_unit_pkg.sv
package spi_unit_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_DIV  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] rsvd;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
  } ctrl_t;
endpackage

// File: rtl/spi_unit_clkdiv.sv
module spi_unit_clkdiv #(
  parameter int CW      = 8,
  parameter int MIN_DIV = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] div_val,
  output logic          tick
);
  localparam int HW = CW - 1;
  localparam logic [CW-1:0] MIN_V = CW'(MIN_DIV);

  logic [CW-1:0] eff;
  logic [HW-1:0] half;
  logic [HW-1:0] cnt;

  // odd or too small divisors fall back to the minimum
  always_comb begin
    eff  = (div_val < MIN_V || div_val[0]) ? MIN_V : div_val;
    half = eff[CW-1:1];
    tick = run && (cnt == half - HW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HW'(1);
  end

  // half period is at least MIN_DIV/2 cycles, so ticks never come back to back
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick) else $error("tick gap violated");
endmodule

// File: rtl/spi_unit_engine.sv
module spi_unit_engine
  import spi_unit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         cfg,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          sdi_i,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          mbusy,
  output logic          sbusy,
  output logic          ss_act,
  output logic          fin,
  output logic          fin_slave,
  output logic          abort,
  output logic [DW-1:0] rx_word
);
  localparam int BW = $clog2(DW + 1);
  localparam int EW = $clog2(2 * DW);

  logic [1:0]    sck_q, ss_q;
  logic          sck_p, sck_lvl;
  logic [DW-1:0] tx, rx, rx_next, tx_next;
  logic [BW-1:0] bits;
  logic [EW-1:0] edg;
  logic          s_edge, lead, ev, samp, shft, m_fin, s_fin;

  always_comb begin
    ss_act  = !ss_q[1];
    s_edge  = !cfg.master && ss_act && (sck_q[1] != sck_p);
    lead    = cfg.master ? !edg[0] : (sck_q[1] != cfg.cpol);
    ev      = cfg.master ? (mbusy && tick) : s_edge;
    samp    = ev && (lead ^ cfg.cpha);
    shft    = ev && !(lead ^ cfg.cpha) && bits != '0 && bits != BW'(DW);
    rx_next = !samp ? rx :
              (cfg.lsb_first ? {sdi_i, rx[DW-1:1]} : {rx[DW-2:0], sdi_i});
    tx_next = cfg.lsb_first ? {1'b0, tx[DW-1:1]} : {tx[DW-2:0], 1'b0};
    m_fin   = mbusy && tick && edg == EW'(2 * DW - 1);
    s_fin   = !cfg.master && samp && bits == BW'(DW - 1);
    fin     = m_fin || s_fin;
    fin_slave = s_fin;
    sbusy   = !cfg.master && bits != '0;
    abort   = !cfg.master && !ss_act && !mbusy && bits != '0;
    rx_word = rx_next;
    sdo_o   = cfg.lsb_first ? tx[0] : tx[DW-1];
    sck_o   = sck_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= '0; ss_q <= 2'b11; sck_p <= 1'b0; sck_lvl <= 1'b0;
      tx <= '0; rx <= '0; bits <= '0; edg <= '0; mbusy <= 1'b0;
    end else begin
      sck_q <= {sck_q[0], sck_i};
      ss_q  <= {ss_q[0], ss_n_i};
      sck_p <= sck_q[1];
      if (cfg.master) begin
        if (start) begin
          mbusy <= 1'b1; tx <= wdata; bits <= '0; edg <= '0;
          sck_lvl <= cfg.cpol;
        end else if (mbusy && tick) begin
          sck_lvl <= ~sck_lvl;
          edg     <= edg + EW'(1);
          rx      <= rx_next;
          if (samp) bits <= bits + BW'(1);
          if (shft) tx <= tx_next;
          if (m_fin) begin
            mbusy <= 1'b0; bits <= '0;
          end
        end else if (!mbusy) begin
          sck_lvl <= cfg.cpol;
        end
      end else begin
        mbusy   <= 1'b0;
        sck_lvl <= cfg.cpol;
        if (start)     tx <= wdata;
        else if (shft) tx <= tx_next;
        rx <= rx_next;
        if (!ss_act || mbusy) bits <= '0;
        else if (samp)        bits <= s_fin ? '0 : bits + BW'(1);
      end
    end
  end

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(mbusy) && cfg.master |-> sck_o == cfg.cpol)
    else $error("serial clock not at idle level after transfer");

  assert_fin_single_R9: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin) else $error("completion repeated");
endmodule

// File: rtl/spi_unit_regs.sv
module spi_unit_regs
  import spi_unit_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          mbusy,
  input  logic          sbusy,
  input  logic          ss_act,
  input  logic          fin,
  input  logic          fin_slave,
  input  logic          abort,
  input  logic [DW-1:0] rx_word,
  output ctrl_t         cfg,
  output logic [CW-1:0] div_val,
  output logic          start
);
  logic [DW-1:0] rx_buf;
  logic done_f, wcol_f, ovr_f, mf_f, abt_f;
  logic seen_done, seen_wcol, seen_mf;
  logic is_data, data_wr, data_acc, stat_rd, ctrl_wr, div_wr, blocked, mf_set, ovr_set;

  always_comb begin
    is_data  = bus_addr == A_DATA;
    data_wr  = bus_wr && is_data;
    data_acc = (bus_wr || bus_rd) && is_data;
    stat_rd  = bus_rd && bus_addr == A_STAT;
    ctrl_wr  = bus_wr && bus_addr == A_CTRL;
    div_wr   = bus_wr && bus_addr == A_DIV;
    blocked  = mbusy || sbusy || (done_f && !seen_done);
    start    = data_wr && !blocked;
    mf_set   = cfg.master && ss_act;
    ovr_set  = fin_slave && done_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0; div_val <= '0; rx_buf <= '0; bus_rdata <= '0;
      done_f <= 1'b0; wcol_f <= 1'b0; ovr_f <= 1'b0; mf_f <= 1'b0; abt_f <= 1'b0;
      seen_done <= 1'b0; seen_wcol <= 1'b0; seen_mf <= 1'b0;
    end else begin
      if (ctrl_wr) cfg <= ctrl_t'({4'b0, bus_wdata[3:0]});
      if (mf_set)  cfg.master <= 1'b0;
      if (div_wr)  div_val <= bus_wdata[CW-1:0];

      if (fin && !ovr_set) rx_buf <= rx_word;

      if (fin)                        done_f <= 1'b1;
      else if (data_acc && seen_done) done_f <= 1'b0;

      if (data_wr && blocked)         wcol_f <= 1'b1;
      else if (data_acc && seen_wcol) wcol_f <= 1'b0;

      if (ovr_set)      ovr_f <= 1'b1;
      else if (stat_rd) ovr_f <= 1'b0;

      if (abort)        abt_f <= 1'b1;
      else if (stat_rd) abt_f <= 1'b0;

      if (mf_set)                  mf_f <= 1'b1;
      else if (ctrl_wr && seen_mf) mf_f <= 1'b0;

      // remember which flags the last status read exposed
      if (stat_rd) begin
        seen_done <= done_f; seen_wcol <= wcol_f;
      end else if (data_acc) begin
        seen_done <= 1'b0; seen_wcol <= 1'b0;
      end
      if (stat_rd)      seen_mf <= mf_f;
      else if (ctrl_wr) seen_mf <= 1'b0;

      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= DW'(cfg);
          A_STAT:  bus_rdata <= DW'({done_f, wcol_f, ovr_f, mf_f, abt_f, 3'b000});
          A_DATA:  bus_rdata <= rx_buf;
          default: bus_rdata <= DW'(div_val);
        endcase
      end
    end
  end

  assert_busy_clash_R3: assert property (@(posedge clk) disable iff (rst)
    data_wr && (mbusy || sbusy) |=> wcol_f) else $error("clash flag missing");

  assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
    done_f && !seen_done && !stat_rd |=> done_f) else $error("done cleared out of sequence");

  assert_fault_drop_R8: assert property (@(posedge clk) disable iff (rst)
    mf_set |=> !cfg.master && mf_f) else $error("fault did not leave master mode");

  assert_ovr_keep_R10: assert property (@(posedge clk) disable iff (rst)
    ovr_set |=> $stable(rx_buf) && ovr_f) else $error("overrun overwrote byte");
endmodule

// File: rtl/spi_unit.sv
module spi_unit
  import spi_unit_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 8,
  parameter int MIN_DIV = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  input  logic          sck_i,
  input  logic          ss_n_i,
  input  logic          sdi_i,
  output logic          sdo_o
);
  ctrl_t         cfg;
  logic [CW-1:0] div_val;
  logic [DW-1:0] rx_word;
  logic start, tick, mbusy, sbusy, ss_act, fin, fin_slave, abort;

  spi_unit_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mbusy(mbusy), .sbusy(sbusy),
    .ss_act(ss_act), .fin(fin), .fin_slave(fin_slave), .abort(abort),
    .rx_word(rx_word), .cfg(cfg), .div_val(div_val), .start(start)
  );

  spi_unit_clkdiv #(.CW(CW), .MIN_DIV(MIN_DIV)) u_div (
    .clk(clk), .rst(rst), .run(mbusy), .div_val(div_val), .tick(tick)
  );

  spi_unit_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .cfg(cfg), .start(start), .wdata(bus_wdata), .tick(tick),
    .sck_i(sck_i), .ss_n_i(ss_n_i), .sdi_i(sdi_i), .sck_o(sck_o), .sdo_o(sdo_o),
    .mbusy(mbusy), .sbusy(sbusy), .ss_act(ss_act), .fin(fin), .fin_slave(fin_slave),
    .abort(abort), .rx_word(rx_word)
  );
endmodule

// File: tb/sim_spi_unit.sv
module sim_spi_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic sck_o, sdo_o;
  logic sck_i = 1'b0, ss_n_i = 1'b1, sdi_drv = 1'b0, lb_en = 1'b0;
  logic sdi_i;
  int n_chk = 0, n_bad = 0;

  // {ctrl, divisor, tx byte, effective divisor}
  localparam logic [31:0] VEC [0:5] = '{
    32'h0408A508, 32'h050C3C0C, 32'h06058108,
    32'h0F095A08, 32'h0C14C314, 32'h07007E08
  };

  always #10 clk = ~clk;
  assign sdi_i = lb_en ? sdo_o : sdi_drv;

  spi_unit u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .sck_i(sck_i),
    .ss_n_i(ss_n_i), .sdi_i(sdi_i), .sdo_o(sdo_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // remote master clocking nb bits, phase 0, idle low
  task automatic slave_byte(input logic lsb, input logic [7:0] txv, input logic [7:0] pat,
                            input int nb, output int bad);
    bad = 0;
    ss_n_i = 1'b0; idle(6);
    for (int i = 0; i < nb; i++) begin
      int k;
      k = lsb ? i : 7 - i;
      if (sdo_o !== txv[k]) bad++;
      sdi_drv = pat[k]; idle(6);
      sck_i = 1'b1; idle(6);
      sck_i = 1'b0; idle(6);
    end
    ss_n_i = 1'b1; idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v, c, dv, tx, eff;
    int bad;
    idle(4);
    rst = 1'b0;
    idle(1);

    rd(2'd0, v); chk("R1 ctrl reset", v, 8'h00);
    rd(2'd1, v); chk("R1 status reset", v, 8'h00);
    rd(2'd2, v); chk("R1 data reset", v, 8'h00);
    rd(2'd3, v); chk("R1 divisor reset", v, 8'h00);
    wr(2'd3, 8'h2A); rd(2'd3, v); chk("R1 divisor readback", v, 8'h2A);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R1 ctrl upper bits zero", v, 8'h0F);
    wr(2'd0, 8'h00); rd(2'd0, v); chk("R1 ctrl cleared", v, 8'h00);

    // master table with loopback
    lb_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      c = VEC[i][31:24]; dv = VEC[i][23:16]; tx = VEC[i][15:8]; eff = VEC[i][7:0];
      wr(2'd3, dv);
      wr(2'd0, c);
      idle(2);
      chk("R2 sck idle level", {7'b0, sck_o}, {7'b0, c[1]});
      wr(2'd2, tx);
      idle(8 * int'(eff) - 1);
      rd(2'd1, v); chk("R4 R6 done not yet set", v, 8'h00);
      rd(2'd1, v); chk("R4 R6 done set on time", v, 8'h80);
      rd(2'd2, v); chk("R2 received byte", v, tx);
      rd(2'd1, v); chk("R5 flags cleared by sequence", v, 8'h00);
    end

    // write clash
    wr(2'd3, 8'h08); wr(2'd0, 8'h04);
    wr(2'd2, 8'h11); idle(4);
    wr(2'd2, 8'h22); idle(70);
    wr(2'd2, 8'h33);
    rd(2'd2, v); chk("R3 blocked writes ignored", v, 8'h11);
    rd(2'd1, v); chk("R5 R3 flags survive data read", v, 8'hC0);
    rd(2'd2, v); chk("R3 byte still first", v, 8'h11);
    rd(2'd1, v); chk("R5 flags cleared", v, 8'h00);

    // select fault
    lb_en = 1'b0;
    ss_n_i = 1'b0; idle(6); ss_n_i = 1'b1; idle(4);
    rd(2'd0, v); chk("R8 master bit dropped", v, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd1, v); chk("R8 fault kept without status read", v, 8'h10);
    wr(2'd0, 8'h00);
    rd(2'd1, v); chk("R8 fault cleared", v, 8'h00);

    // slave msb first
    wr(2'd0, 8'h00); wr(2'd2, 8'hA5);
    slave_byte(1'b0, 8'hA5, 8'h3C, 8, bad);
    chk("R9 msb-first output bits", 8'(bad), 8'h00);
    rd(2'd1, v); chk("R9 done after eighth sample", v, 8'h80);
    rd(2'd2, v); chk("R9 msb-first received", v, 8'h3C);
    rd(2'd1, v); chk("R9 status clear", v, 8'h00);

    // slave lsb first
    wr(2'd0, 8'h08); wr(2'd2, 8'h96);
    slave_byte(1'b1, 8'h96, 8'h5A, 8, bad);
    chk("R9 lsb-first output bits", 8'(bad), 8'h00);
    rd(2'd1, v); chk("R9 lsb done", v, 8'h80);
    rd(2'd2, v); chk("R9 lsb-first received", v, 8'h5A);
    rd(2'd1, v); chk("R9 lsb status clear", v, 8'h00);

    // overrun
    wr(2'd0, 8'h00); wr(2'd2, 8'h11);
    slave_byte(1'b0, 8'h11, 8'h3C, 8, bad);
    slave_byte(1'b0, 8'h00, 8'h99, 8, bad);
    rd(2'd1, v); chk("R10 overrun flag", v, 8'hA0);
    rd(2'd2, v); chk("R10 first byte kept", v, 8'h3C);
    rd(2'd1, v); chk("R10 overrun cleared by read", v, 8'h00);

    // slave abort
    slave_byte(1'b0, 8'h00, 8'hF0, 2, bad);
    rd(2'd1, v); chk("R7 abort flag", v, 8'h08);
    rd(2'd1, v); chk("R7 abort cleared by read", v, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule